// File: doc/BRIEF.md
# Synthesizer Serial Programming Receiver

This block is the receiving end of a three-line programming port for a frequency synthesizer. A host drives a data line, a shift clock and a load strobe. The block brings all three lines into its own system clock domain and shifts in one bit on each rising edge of the shift clock. When the load strobe rises, it commits the 24-bit word into one of four latches. The two lowest bits of the word pick the latch.

The latches are decoded into parallel control fields:

- **Reference latch:** the reference divider and its side settings.
- **N latch:** the A and B counters and the charge-pump gain bit.
- **Function latch and initialization latch:** one shared set of loop controls. These are charge-pump currents, timer, output-mux selection, polarity, fastlock and power-down bits, and the prescaler choice.

A write through the initialization address also gives a one-cycle counter-reset pulse and sets a sticky initialized flag. A word committed after the wrong number of shift clocks is thrown away and reported with an error pulse.

Top module: `synth_prog_rx`

## Requirements
- R1: Each serial input passes through two synchronizing flops. A field change, the counter-reset pulse or the error pulse appears on the third rising system clock edge after the load line goes high.
- R2: One data bit is taken on each rising edge of the shift clock, most significant bit first. The first bit sent becomes word bit 23 and the last becomes bit 0.
- R3: Word bits 1:0 select the target latch: 00 reference, 01 N, 10 function, 11 initialization. Only the fields of the addressed latch change.
- R4: Reference latch fields: `ref_div` = bits 15:2, `ab_width` = bits 17:16, `test_mode` = bits 19:18, `ld_precise` = bit 20. Bits 23:21 are ignored.
- R5: N latch fields: `a_cnt` = bits 7:2, `b_cnt` = bits 20:8, `cp_gain` = bit 21. Bits 23:22 are ignored.
- R6: Function layout fields:
  - `cnt_rst_bit` = bit 2, `pwr_dn1` = bit 3, `mux_sel` = bits 6:4, `pd_pol` = bit 7.
  - `cp_tristate` = bit 8, `fast_en` = bit 9, `fast_mode` = bit 10, `timer_sel` = bits 14:11.
  - `cur_set1` = bits 17:15, `cur_set2` = bits 20:18, `pwr_dn2` = bit 21, `presc_sel` = bits 23:22.
- R7: An initialization write loads the same function fields. It also raises `cnt_rst_pulse` for exactly one cycle and sets `init_done`. `init_done` then stays high until reset.
- R8: If the load line rises after any bit count other than 24, no field changes and `frame_err` is high for exactly one cycle.
- R9: While synchronous active-low reset is applied, every field output and every flag is 0.
- R10: Each rise of the load line restarts the bit count. A correct 24-bit word that follows a bad frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock |
| ser_load | input | 1 | Load strobe; its rising edge commits the word |
| ref_div | output | 14 | Reference divider |
| ab_width | output | 2 | Anti-backlash pulse width |
| test_mode | output | 2 | Test-mode bits |
| ld_precise | output | 1 | Lock-detect precision |
| a_cnt | output | 6 | A counter |
| b_cnt | output | 13 | B counter |
| cp_gain | output | 1 | Charge-pump gain select |
| cnt_rst_bit | output | 1 | Counter-reset control bit |
| pwr_dn1 | output | 1 | Power-down control 1 |
| mux_sel | output | 3 | Output-mux selection |
| pd_pol | output | 1 | Phase-detector polarity |
| cp_tristate | output | 1 | Charge-pump three-state |
| fast_en | output | 1 | Fastlock enable |
| fast_mode | output | 1 | Fastlock mode |
| timer_sel | output | 4 | Timer counter setting |
| cur_set1 | output | 3 | Charge-pump current setting 1 |
| cur_set2 | output | 3 | Charge-pump current setting 2 |
| pwr_dn2 | output | 1 | Power-down control 2 |
| presc_sel | output | 2 | Prescaler selection |
| cnt_rst_pulse | output | 1 | One-cycle pulse on an initialization write |
| init_done | output | 1 | Sticky flag set by an initialization write |
| frame_err | output | 1 | One-cycle pulse when a word with a bad bit count is dropped |

## Verification
The assertions assume two things about the host:

- Every serial line holds each level for at least three system clock cycles, so no synchronized edge is missed or merged.
- The load line stays low while bits are shifted.

Under those conditions a commit and an error can never fall in the same cycle, and pulses never come back to back. The stimulus keeps to this by setting data two cycles before each shift-clock rise. It also holds each level for several cycles and raises the load line only after the shift clock has returned low. Short frames (23 bits) and long frames (25 bits) are sent between good words, so the restart of the bit count is exercised as well.

// File: rtl/synth_prog_pkg.sv
// Shared constants and types for the synthesizer programming receiver.
// Assumes the word is 24 bits and the latch address sits in bits 1:0.
package synth_prog_pkg;
    localparam int WORD_W = 24;
    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        SEL_REF  = 2'b00,
        SEL_N    = 2'b01,
        SEL_FUNC = 2'b10,
        SEL_INIT = 2'b11
    } latch_sel_e;

    // Shared function/initialization layout, word bits 23:2, MSB first
    typedef struct packed {
        logic [1:0] presc;
        logic       pd2;
        logic [2:0] cur2;
        logic [2:0] cur1;
        logic [3:0] timer;
        logic       fl_mode;
        logic       fl_en;
        logic       cp_tri;
        logic       pd_pol;
        logic [2:0] mux;
        logic       pd1;
        logic       crst;
    } func_fields_t;
endpackage

// File: rtl/serial_front.sv
// Synchronizes the three serial lines into clk and finds the rising edges
// of the shift clock and load strobe. Assumes each line level is held for
// more than SYNC_STAGES+1 system clocks. Data is delayed as much as the
// clock, so the sampled bit lines up with the detected edge.
module serial_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_data,
    input  logic ser_clk,
    input  logic ser_load,
    output logic bit_val,
    output logic clk_rise,
    output logic load_rise
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES:0] pipe_d;
    logic [SYNC_STAGES:0] pipe_c;
    logic [SYNC_STAGES:0] pipe_l;

    // Shift each line through its synchronizer chain plus one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_d <= '0;
            pipe_c <= '0;
            pipe_l <= '0;
        end else begin
            pipe_d <= {pipe_d[SYNC_STAGES-1:0], ser_data};
            pipe_c <= {pipe_c[SYNC_STAGES-1:0], ser_clk};
            pipe_l <= {pipe_l[SYNC_STAGES-1:0], ser_load};
        end
    end

    // Edge detection on the synchronized copies
    always_comb begin
        bit_val   = pipe_d[LAST];
        clk_rise  = pipe_c[LAST] & ~pipe_c[SYNC_STAGES];
        load_rise = pipe_l[LAST] & ~pipe_l[SYNC_STAGES];
    end
endmodule

// File: rtl/word_shifter.sv
// Collects serial bits MSB first and counts them. When the load edge comes,
// it flags the word as good (exactly WORD_W bits) or bad, and restarts the
// count. The count saturates at WORD_W+1 so long frames stay bad.
module word_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_val,
    input  logic              clk_rise,
    input  logic              load_rise,
    output logic [WORD_W-1:0] word,
    output logic              word_good,
    output logic              word_bad
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

    logic [CNT_W-1:0] bit_cnt;

    // Shift register and saturating bit counter; the load edge clears the count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word    <= '0;
            bit_cnt <= '0;
        end else if (load_rise) begin
            bit_cnt <= '0;
        end else if (clk_rise) begin
            word <= {word[WORD_W-2:0], bit_val};
            if (bit_cnt != OVER) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Judge the frame length at the load edge
    always_comb begin
        word_good = load_rise && (bit_cnt == FULL);
        word_bad  = load_rise && (bit_cnt != FULL);
    end
endmodule

// File: rtl/latch_bank.sv
// Holds the reference, N and function latches and decodes the address bits.
// An initialization write fills the function latch, pulses the counter reset
// and sets the sticky initialized flag. A bad frame gives a one-cycle error.
module latch_bank
    import synth_prog_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic              word_good,
    input  logic              word_bad,
    output logic [18:0]       ref_q,
    output logic [19:0]       n_q,
    output func_fields_t      func_q,
    output logic              crst_pulse,
    output logic              init_flag,
    output logic              err_pulse
);
    latch_sel_e sel;

    // Address decode from the two lowest word bits
    always_comb sel = latch_sel_e'(word[ADDR_W-1:0]);

    // Commit a good word into the addressed latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= '0;
            n_q    <= '0;
            func_q <= '0;
        end else if (word_good) begin
            unique case (sel)
                SEL_REF:  ref_q  <= word[20:2];
                SEL_N:    n_q    <= word[21:2];
                SEL_FUNC,
                SEL_INIT: func_q <= func_fields_t'(word[23:2]);
            endcase
        end
    end

    // Status: reset pulse, sticky init flag, framing error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crst_pulse <= 1'b0;
            init_flag  <= 1'b0;
            err_pulse  <= 1'b0;
        end else begin
            crst_pulse <= word_good && (sel == SEL_INIT);
            err_pulse  <= word_bad;
            if (word_good && (sel == SEL_INIT)) init_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/synth_prog_rx.sv
// Top of the synthesizer programming receiver. It joins the synchronizing
// front end, the word shifter and the latch bank, and puts every decoded
// field on its own output port. It assumes a 24-bit word with the latch
// address in bits 1:0.
module synth_prog_rx
    import synth_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_data,
    input  logic        ser_clk,
    input  logic        ser_load,
    output logic [13:0] ref_div,
    output logic [1:0]  ab_width,
    output logic [1:0]  test_mode,
    output logic        ld_precise,
    output logic [5:0]  a_cnt,
    output logic [12:0] b_cnt,
    output logic        cp_gain,
    output logic        cnt_rst_bit,
    output logic        pwr_dn1,
    output logic [2:0]  mux_sel,
    output logic        pd_pol,
    output logic        cp_tristate,
    output logic        fast_en,
    output logic        fast_mode,
    output logic [3:0]  timer_sel,
    output logic [2:0]  cur_set1,
    output logic [2:0]  cur_set2,
    output logic        pwr_dn2,
    output logic [1:0]  presc_sel,
    output logic        cnt_rst_pulse,
    output logic        init_done,
    output logic        frame_err
);
    logic              bit_val, clk_rise, load_rise;
    logic [WORD_W-1:0] word;
    logic              word_good, word_bad;
    logic [18:0]       ref_q;
    logic [19:0]       n_q;
    func_fields_t      func_q;

    serial_front #(.SYNC_STAGES(SYNC_STAGES)) front_i (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_load(ser_load), .bit_val(bit_val), .clk_rise(clk_rise),
        .load_rise(load_rise)
    );

    word_shifter #(.WORD_W(WORD_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .bit_val(bit_val), .clk_rise(clk_rise),
        .load_rise(load_rise), .word(word), .word_good(word_good),
        .word_bad(word_bad)
    );

    latch_bank #(.WORD_W(WORD_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .word(word), .word_good(word_good),
        .word_bad(word_bad), .ref_q(ref_q), .n_q(n_q), .func_q(func_q),
        .crst_pulse(cnt_rst_pulse), .init_flag(init_done),
        .err_pulse(frame_err)
    );

    // Split the stored latches into their output fields
    always_comb begin
        ref_div     = ref_q[13:0];
        ab_width    = ref_q[15:14];
        test_mode   = ref_q[17:16];
        ld_precise  = ref_q[18];
        a_cnt       = n_q[5:0];
        b_cnt       = n_q[18:6];
        cp_gain     = n_q[19];
        cnt_rst_bit = func_q.crst;
        pwr_dn1     = func_q.pd1;
        mux_sel     = func_q.mux;
        pd_pol      = func_q.pd_pol;
        cp_tristate = func_q.cp_tri;
        fast_en     = func_q.fl_en;
        fast_mode   = func_q.fl_mode;
        timer_sel   = func_q.timer;
        cur_set1    = func_q.cur1;
        cur_set2    = func_q.cur2;
        pwr_dn2     = func_q.pd2;
        presc_sel   = func_q.presc;
    end
endmodule

// File: rtl/synth_prog_rx_chk.sv
// Temporal checks on the receiver's ports. Assumes the host holds every
// serial line level for several system clocks and keeps load low while
// shifting.
module synth_prog_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [13:0] ref_div,
    input logic [5:0]  a_cnt,
    input logic [12:0] b_cnt,
    input logic [3:0]  timer_sel,
    input logic [1:0]  presc_sel,
    input logic        cnt_rst_pulse,
    input logic        init_done,
    input logic        frame_err
);
    // R7
    init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R7
    rst_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst_pulse |=> !cnt_rst_pulse);

    // R7
    rst_pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst_pulse |-> init_done);

    // R8
    err_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    // R8
    err_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> ($stable(ref_div) && $stable(a_cnt) && $stable(b_cnt)
                       && $stable(timer_sel) && $stable(presc_sel)
                       && !cnt_rst_pulse));
endmodule

bind synth_prog_rx synth_prog_rx_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .a_cnt(a_cnt),
    .b_cnt(b_cnt), .timer_sel(timer_sel), .presc_sel(presc_sel),
    .cnt_rst_pulse(cnt_rst_pulse), .init_done(init_done),
    .frame_err(frame_err)
);

// File: tb/synth_prog_rx_test.sv
module synth_prog_rx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0, ser_clk = 1'b0, ser_load = 1'b0;
    logic [13:0] ref_div;  logic [1:0] ab_width, test_mode; logic ld_precise;
    logic [5:0] a_cnt;     logic [12:0] b_cnt; logic cp_gain;
    logic cnt_rst_bit, pwr_dn1, pd_pol, cp_tristate, fast_en, fast_mode, pwr_dn2;
    logic [2:0] mux_sel, cur_set1, cur_set2; logic [3:0] timer_sel;
    logic [1:0] presc_sel; logic cnt_rst_pulse, init_done, frame_err;

    always #10 clk = ~clk; // 50 MHz

    synth_prog_rx uut (.*);

    int checks = 0, fails = 0, cyc = 0;
    bit done = 1'b0;

    // Reference model state
    bit  bitq[$];
    logic [23:0] e_ref = '0, e_n = '0, e_fn = '0;
    bit e_init = 1'b0;
    bit pend = 1'b0, pend_ok = 1'b0;
    logic [23:0] pend_word = '0;
    int commit_cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            if (fails < 20)
                $display("FAIL %s %s actual=%h expected=%h (cycle %0d)",
                         req, what, act, exp, cyc);
        end
    endtask

    // Compare every output against the model on each falling edge
    always @(negedge clk) begin
        bit pulse_init, pulse_err;
        pulse_init = 1'b0; pulse_err = 1'b0;
        if (pend && cyc > commit_cyc) pend = 1'b0;
        if (pend && cyc == commit_cyc) begin
            if (pend_ok) begin
                case (pend_word[1:0])
                    2'b00: e_ref = pend_word;
                    2'b01: e_n   = pend_word;
                    default: e_fn = pend_word;
                endcase
                if (pend_word[1:0] == 2'b11) begin
                    e_init = 1'b1; pulse_init = 1'b1;
                end
            end else pulse_err = 1'b1;
        end
        if (cyc >= 2 && !done) begin
            // R4 reference fields
            chk({ref_div, ab_width, test_mode, ld_precise} ===
                {e_ref[15:2], e_ref[17:16], e_ref[19:18], e_ref[20]},
                "R4", "ref fields",
                24'({ref_div, ab_width, test_mode, ld_precise}),
                24'({e_ref[15:2], e_ref[17:16], e_ref[19:18], e_ref[20]}));
            // R5 N fields
            chk({a_cnt, b_cnt, cp_gain} === {e_n[7:2], e_n[20:8], e_n[21]},
                "R5", "N fields", 24'({a_cnt, b_cnt, cp_gain}),
                24'({e_n[7:2], e_n[20:8], e_n[21]}));
            // R6 function fields
            chk({presc_sel, pwr_dn2, cur_set2, cur_set1, timer_sel, fast_mode,
                 fast_en, cp_tristate, pd_pol, mux_sel, pwr_dn1, cnt_rst_bit}
                === e_fn[23:2], "R6", "function fields",
                24'({presc_sel, pwr_dn2, cur_set2, cur_set1, timer_sel,
                     fast_mode, fast_en, cp_tristate, pd_pol, mux_sel,
                     pwr_dn1, cnt_rst_bit}), 24'(e_fn[23:2]));
            // R7 init pulse and sticky flag
            chk(cnt_rst_pulse === pulse_init && init_done === e_init, "R7",
                "init pulse/flag", 24'({cnt_rst_pulse, init_done}),
                24'({pulse_init, e_init}));
            // R8 error pulse
            chk(frame_err === pulse_err, "R8", "frame_err",
                24'(frame_err), 24'(pulse_err));
        end
    end

    // R2: one bit per shift clock, MSB first
    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); ser_data = v[i]; bitq.push_back(v[i]);
            repeat (2) @(negedge clk); ser_clk = 1'b1;
            repeat (3) @(negedge clk); ser_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    // R1: commit lands on the third rising edge after the load rises
    task automatic do_load();
        logic [23:0] w;
        w = '0;
        foreach (bitq[k]) w = {w[22:0], logic'(bitq[k])};
        @(negedge clk);
        pend_ok = (bitq.size() == 24);
        pend_word = w;
        commit_cyc = cyc + 3;
        pend = 1'b1;
        ser_load = 1'b1;
        bitq.delete();
        repeat (6) @(negedge clk); ser_load = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic write_word(input logic [31:0] v, input int n);
        send_bits(v, n);
        do_load();
    endtask

    initial begin
        // R9: reset state checked by the per-cycle compare
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        write_word(32'h0A51C4, 24);  // R3 R4 reference latch
        write_word(32'h3C5E2D, 24);  // R3 R5 N latch
        write_word(32'h6B3E96, 24);  // R3 R6 function latch
        write_word(32'h8000AA, 23);  // R8 short frame
        write_word(32'h1ABCDE5, 25); // R8 long frame
        write_word(32'hE7F3F9, 24);  // R10 good word after bad frames (N)
        write_word(32'h94C1F7, 24);  // R7 initialization latch
        write_word(32'hFFFFFC, 24);  // R4 reserved bits ignored, all-ones ref
        write_word(32'h2A9562, 24);  // R6 function write after init
        write_word(32'h000003, 24);  // R7 second init, flag stays set
        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule